// File: doc/BRIEF.md
# Masked Content-Addressable Memory with Priority Resolution

This block holds a small table of entries (16 entries of 64 bits by default), each with its own valid bit. It compares a search key, the comparand, against every valid entry in parallel. An optional bit mask turns chosen key bits into don't-care positions. The per-entry hit lines go to a priority encoder. The encoder reports the lowest hitting index, a hit flag and a multi-hit flag. A second encoder over the free entries gives the lowest unused slot and a full flag.

A host drives the block through a single command port: one command per clock, qualified by `cmd_valid`. Commands load the comparand, the mask or the control word, force a compare, write data or move the comparand into the table, invalidate an entry, load the address pointer, or read an entry back. A write can go to an absolute index, to the address pointer, to the index of the last compare's best hit, or to the lowest free slot. The mask can also shield chosen bits of the destination entry from a write.

Top module: `masked_cam`

## Requirements
- R1: After reset, every entry is invalid and memory reads as zero. Comparand, mask, control word and address pointer are zero. `st_match`, `st_multi`, `st_full` and `full` are 0, and `free_addr` and `st_addr` are 0.
- R2: An entry hits when its valid bit is set and it equals the comparand on every bit where the compare mask is 0. The compare mask is the mask register when control bit 0 is 1, and all zeros otherwise.
- R3: `st_addr` holds the lowest-numbered hitting entry. When nothing hits, `st_match` is 0 and `st_addr` is 0.
- R4: `st_multi` is 1 exactly when two or more entries hit.
- R5: A compare runs on each accepted command with op 0 (load comparand from `cmd_data`), op 1 (load mask), op 2 (load control word from `cmd_data[1:0]`) or op 3 (forced compare). The compare uses the newly loaded value, and its results appear after that same clock edge. All other commands and idle cycles leave `st_addr`, `st_match`, `st_multi` and `st_full` unchanged.
- R6: `free_addr` is the lowest-numbered invalid entry, and `full` is 1 when no entry is invalid, with `free_addr` then 0. `st_full` captures `full` as it was at the compare.
- R7: Op 4 writes `cmd_data` to a destination chosen by `cmd_dest`: 0 selects `cmd_addr`, 1 the address pointer, 2 the stored `st_addr`, and 3 the current `free_addr`. Destination 2 is skipped when `st_match` is 0, and destination 3 is skipped when `full` is 1. A performed write sets the entry's valid bit.
- R8: When `cmd_masked` is 1 on a write or move, every bit that is 1 in the mask register keeps its old value in the destination entry.
- R9: Op 5 (move) writes the comparand register to the destination, using the same destination rules as R7.
- R10: Op 6 clears the valid bit of entry `cmd_addr`, which takes it out of compares and makes it available as a free slot.
- R11: Op 7 loads the address pointer `addr_ptr` from `cmd_addr`. When control bit 1 is 1, each write or move with destination 1 then increments the pointer, wrapping from the last entry to 0.
- R12: Op 8 returns entry `cmd_addr` on `rd_data` and its valid bit on `rd_valid` after the accepting edge. Ops 9 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_dest | input | 2 | Write/move destination select |
| cmd_masked | input | 1 | Protect mask-set bits on write/move |
| cmd_addr | input | AW | Entry index / pointer load value |
| cmd_data | input | WIDTH | Data operand |
| rd_data | output | WIDTH | Entry read back |
| rd_valid | output | 1 | Valid bit of the entry read back |
| st_addr | output | AW | Lowest hitting index from last compare |
| st_match | output | 1 | Last compare found a hit |
| st_multi | output | 1 | Last compare found two or more hits |
| st_full | output | 1 | Full flag captured at last compare |
| free_addr | output | AW | Lowest invalid entry |
| full | output | 1 | No invalid entry |
| addr_ptr | output | AW | Address pointer |

## Verification
Compare status, read data, the pointer and the free/full outputs all reflect a command one edge after the edge that accepts it. Compare results use the value loaded by that same command. The bench drives each command on a falling edge and holds it across one rising edge. It then drops `cmd_valid` and checks all outputs on the next falling edge. A reference model in the bench, updated at the same step, supplies the expected values.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [3:0] {
    OP_SET_KEY  = 4'd0,
    OP_SET_MASK = 4'd1,
    OP_SET_CTRL = 4'd2,
    OP_SEARCH   = 4'd3,
    OP_WRITE    = 4'd4,
    OP_MOVE     = 4'd5,
    OP_CLEAR    = 4'd6,
    OP_LOAD_PTR = 4'd7,
    OP_READ     = 4'd8
  } cam_op_e;

  typedef enum logic [1:0] {
    DST_ABS  = 2'd0,
    DST_PTR  = 2'd1,
    DST_HIT  = 2'd2,
    DST_FREE = 2'd3
  } cam_dst_e;

  localparam int CTRL_W      = 2;
  localparam int CTRL_MASKEN = 0;
  localparam int CTRL_AUTOINC = 1;

endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N  = 16,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [AW-1:0] idx,
  output logic          any,
  output logic          multi
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end

  assign any   = |vec;
  assign multi = |(vec & (vec - N'(1)));

endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] entries,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [WIDTH-1:0]              key,
  input  logic [WIDTH-1:0]              dont_care,
  output logic [ENTRIES-1:0]            hit
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    assign hit[g] = valid[g] && (((entries[g] ^ key) & ~dont_care) == '0);
  end

endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic [WIDTH-1:0]              wdata,
  input  logic [WIDTH-1:0]              wprot,
  input  logic                          clr,
  input  logic [AW-1:0]                 caddr,
  input  logic                          re,
  input  logic [AW-1:0]                 raddr,
  output logic [WIDTH-1:0]              rdata,
  output logic                          rvalid,
  output logic [ENTRIES-1:0][WIDTH-1:0] entries,
  output logic [ENTRIES-1:0]            valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      entries <= '0;
      valid   <= '0;
    end else begin
      if (we) begin
        entries[waddr] <= (entries[waddr] & wprot) | (wdata & ~wprot);
        valid[waddr]   <= 1'b1;
      end else if (clr) begin
        valid[caddr] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (re) begin
      rdata  <= entries[raddr];
      rvalid <= valid[raddr];
    end
  end

endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [1:0]       cmd_dest,
  input  logic             cmd_masked,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [WIDTH-1:0] cmd_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic [AW-1:0]    st_addr,
  output logic             st_match,
  output logic             st_multi,
  output logic             st_full,
  output logic [AW-1:0]    free_addr,
  output logic             full,
  output logic [AW-1:0]    addr_ptr
);

  cam_op_e  op;
  cam_dst_e dst;
  logic [WIDTH-1:0]  key_q, key_nx, mask_q, mask_nx, dont_care;
  logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
  logic [AW-1:0]     ptr_q;
  logic              do_search, is_wr, dst_ok, we, clr, re;
  logic [AW-1:0]     dst_addr;
  logic [WIDTH-1:0]  wdata, wprot;

  logic [ENTRIES-1:0][WIDTH-1:0] entries;
  logic [ENTRIES-1:0]            valid, hit;
  logic [AW-1:0]                 hit_idx, free_idx;
  logic                          hit_any, hit_multi, free_any, free_multi;

  assign op  = cam_op_e'(cmd_op);
  assign dst = cam_dst_e'(cmd_dest);

  always_comb begin
    key_nx  = key_q;
    mask_nx = mask_q;
    ctrl_nx = ctrl_q;
    if (cmd_valid && op == OP_SET_KEY)  key_nx  = cmd_data;
    if (cmd_valid && op == OP_SET_MASK) mask_nx = cmd_data;
    if (cmd_valid && op == OP_SET_CTRL) ctrl_nx = cmd_data[CTRL_W-1:0];
  end

  assign do_search = cmd_valid && (op == OP_SET_KEY || op == OP_SET_MASK ||
                                   op == OP_SET_CTRL || op == OP_SEARCH);
  assign dont_care = ctrl_nx[CTRL_MASKEN] ? mask_nx : '0;

  always_comb begin
    dst_ok   = 1'b1;
    dst_addr = cmd_addr;
    unique case (dst)
      DST_ABS:  dst_addr = cmd_addr;
      DST_PTR:  dst_addr = ptr_q;
      DST_HIT:  begin dst_addr = st_addr;  dst_ok = st_match; end
      DST_FREE: begin dst_addr = free_idx; dst_ok = free_any; end
      default:  dst_ok = 1'b0;
    endcase
  end

  assign is_wr = cmd_valid && (op == OP_WRITE || op == OP_MOVE);
  assign we    = is_wr && dst_ok;
  assign wdata = (op == OP_MOVE) ? key_q : cmd_data;
  assign wprot = cmd_masked ? mask_q : '0;
  assign clr   = cmd_valid && op == OP_CLEAR;
  assign re    = cmd_valid && op == OP_READ;

  cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst),
    .we(we), .waddr(dst_addr), .wdata(wdata), .wprot(wprot),
    .clr(clr), .caddr(cmd_addr),
    .re(re), .raddr(cmd_addr),
    .rdata(rd_data), .rvalid(rd_valid),
    .entries(entries), .valid(valid)
  );

  cam_match_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
    .entries(entries), .valid(valid), .key(key_nx),
    .dont_care(dont_care), .hit(hit)
  );

  cam_prio_enc #(.N(ENTRIES)) u_hit_enc (
    .vec(hit), .idx(hit_idx), .any(hit_any), .multi(hit_multi)
  );

  cam_prio_enc #(.N(ENTRIES)) u_free_enc (
    .vec(~valid), .idx(free_idx), .any(free_any), .multi(free_multi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      ptr_q  <= '0;
    end else begin
      key_q  <= key_nx;
      mask_q <= mask_nx;
      ctrl_q <= ctrl_nx;
      if (cmd_valid && op == OP_LOAD_PTR)
        ptr_q <= cmd_addr;
      else if (is_wr && dst == DST_PTR && ctrl_q[CTRL_AUTOINC])
        ptr_q <= (ptr_q == AW'(ENTRIES - 1)) ? '0 : ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_addr  <= '0;
      st_match <= 1'b0;
      st_multi <= 1'b0;
      st_full  <= 1'b0;
    end else if (do_search) begin
      st_addr  <= hit_idx;
      st_match <= hit_any;
      st_multi <= hit_multi;
      st_full  <= ~free_any;
    end
  end

  assign free_addr = free_idx;
  assign full      = ~free_any;
  assign addr_ptr  = ptr_q;

endmodule

// File: rtl/masked_cam_chk.sv
module masked_cam_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic [AW-1:0] st_addr,
  input logic          st_match,
  input logic          st_multi,
  input logic          st_full,
  input logic [AW-1:0] free_addr,
  input logic          full,
  input logic [AW-1:0] addr_ptr
);

  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> !st_match && !full && addr_ptr == '0); // R1
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst) !st_match |-> st_addr == '0); // R3
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst) st_multi |-> st_match); // R4
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op <= 4'd3) |=> $stable(st_addr) && $stable(st_match) && $stable(st_multi) && $stable(st_full)); // R5
  AST_FULL_FREE_ZERO: assert property (@(posedge clk) disable iff (rst) full |-> free_addr == '0); // R6
  AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == 4'd6 |=> !full && free_addr <= $past(cmd_addr)); // R10
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == 4'd7 |=> addr_ptr == $past(cmd_addr)); // R11

endmodule

bind masked_cam masked_cam_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .st_addr(st_addr), .st_match(st_match), .st_multi(st_multi), .st_full(st_full),
  .free_addr(free_addr), .full(full), .addr_ptr(addr_ptr)
);

// File: tb/masked_cam_tb.sv
module masked_cam_tb;
  localparam int N = 16;
  localparam int W = 64;
  localparam int AW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_masked = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_dest = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, st_match, st_multi, st_full, full;
  logic [AW-1:0] st_addr, free_addr, addr_ptr;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [W-1:0] m_mem [N];
  bit           m_val [N];
  logic [W-1:0] m_key, m_mask, m_rd;
  logic [1:0]   m_ctrl;
  logic [AW-1:0] m_ptr, m_saddr;
  bit m_match, m_multi, m_sfull, m_rdv;

  always #4 clk = ~clk;

  masked_cam #(.ENTRIES(N), .WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dest(cmd_dest),
    .cmd_masked(cmd_masked), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .st_addr(st_addr), .st_match(st_match),
    .st_multi(st_multi), .st_full(st_full), .free_addr(free_addr), .full(full),
    .addr_ptr(addr_ptr)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    return -1;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin m_mem[i] = '0; m_val[i] = 0; end
    m_key = '0; m_mask = '0; m_ctrl = '0; m_ptr = '0; m_saddr = '0;
    m_match = 0; m_multi = 0; m_sfull = 0; m_rd = '0; m_rdv = 0;
  endtask

  task automatic m_apply(int op, int dst, bit msk, int a, logic [W-1:0] d);
    int dest; bit ok; logic [W-1:0] dc, prot, wd; int cnt;
    if (op == 0) m_key = d;
    if (op == 1) m_mask = d;
    if (op == 2) m_ctrl = d[1:0];
    if (op <= 3) begin
      dc = m_ctrl[0] ? m_mask : '0;
      cnt = 0; m_saddr = '0;
      for (int i = N - 1; i >= 0; i--)
        if (m_val[i] && (((m_mem[i] ^ m_key) & ~dc) == '0)) begin cnt++; m_saddr = AW'(i); end
      m_match = cnt > 0; m_multi = cnt > 1; m_sfull = (m_free() < 0);
    end
    if (op == 4 || op == 5) begin
      ok = 1; dest = a;
      if (dst == 1) dest = m_ptr;
      if (dst == 2) begin dest = m_saddr; ok = m_match; end
      if (dst == 3) begin dest = m_free(); ok = dest >= 0; end
      wd = (op == 5) ? m_key : d;
      prot = msk ? m_mask : '0;
      if (ok) begin
        m_mem[dest] = (m_mem[dest] & prot) | (wd & ~prot);
        m_val[dest] = 1;
      end
      if (dst == 1 && m_ctrl[1]) m_ptr = m_ptr + 1'b1;
    end
    if (op == 6) m_val[a] = 0;
    if (op == 7) m_ptr = AW'(a);
    if (op == 8) begin m_rd = m_mem[a]; m_rdv = m_val[a]; end
  endtask

  task automatic check_all(string tag);
    int f = m_free();
    check({tag, " R3 st_addr"}, W'(st_addr), W'(m_saddr));
    check({tag, " R2 st_match"}, W'(st_match), W'(m_match));
    check({tag, " R4 st_multi"}, W'(st_multi), W'(m_multi));
    check({tag, " R6 st_full"}, W'(st_full), W'(m_sfull));
    check({tag, " R6 full"}, W'(full), W'(f < 0));
    check({tag, " R6 free_addr"}, W'(free_addr), W'((f < 0) ? 0 : f));
    check({tag, " R11 addr_ptr"}, W'(addr_ptr), W'(m_ptr));
    check({tag, " R12 rd_data"}, rd_data, m_rd);
    check({tag, " R12 rd_valid"}, W'(rd_valid), W'(m_rdv));
  endtask

  task automatic issue(string tag, int op, int dst, bit msk, int a, logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'(op); cmd_dest = 2'(dst); cmd_masked = msk;
    cmd_addr = AW'(a); cmd_data = d;
    m_apply(op, dst, msk, a, d);
    @(negedge clk);
    cmd_valid = 0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset match", W'(st_match), 0);
    check("R1 reset full", W'(full), 0);
    check("R1 reset free", W'(free_addr), 0);
    check_all("R1");

    // R7 fill every slot through the free destination
    for (int i = 0; i < N; i++) issue("R7 fill", 4, 3, 0, 0, W'(i % 4));
    check("R6 full after fill", W'(full), 1);
    issue("R7 free when full skipped", 4, 3, 0, 0, 64'hdead);
    issue("R7 read slot0", 8, 0, 0, 0, 0);
    check("R7 slot0 untouched", rd_data, 0);

    // R3 R4 multiple hits resolve to lowest index
    issue("R5 key", 0, 0, 0, 0, 64'd1);
    check("R3 lowest hit", W'(st_addr), 1);
    check("R4 multi", W'(st_multi), 1);
    issue("R2 mask", 1, 0, 0, 0, 64'd2);
    issue("R2 mask enable", 2, 0, 0, 0, 64'd1);
    issue("R2 key3 masked", 0, 0, 0, 0, 64'd3);
    check("R2 masked hit at 1", W'(st_addr), 1);
    issue("R2 miss", 0, 0, 0, 0, 64'h100);
    check("R3 miss", W'(st_match), 0);
    issue("R7 hit dest skipped", 4, 2, 0, 0, 64'h55);

    // R10 clear and refill
    issue("R10 clear 5", 6, 0, 0, 5, 0);
    check("R10 free 5", W'(free_addr), 5);
    issue("R9 move to free", 5, 3, 0, 0, 0);
    issue("R12 read 5", 8, 0, 0, 5, 0);
    check("R9 moved key", rd_data, 64'h100);

    // R8 masked write
    issue("R8 mask", 1, 0, 0, 0, 64'h00ff);
    issue("R8 masked write", 4, 0, 1, 7, 64'hffff_ffff);
    issue("R8 read", 8, 0, 0, 7, 0);
    check("R8 protected low byte", rd_data, 64'hffff_ff03);

    // R11 pointer wrap
    issue("R11 ctrl", 2, 0, 0, 0, 64'd2);
    issue("R11 load", 7, 0, 0, 15, 0);
    issue("R11 wr1", 4, 1, 0, 0, 64'h11);
    check("R11 wrapped", W'(addr_ptr), 0);
    issue("R11 wr2", 5, 1, 0, 0, 0);
    issue("R12 idle op", 12, 0, 0, 3, 64'h77);

    for (int k = 0; k < 3000; k++) begin
      int op = $urandom % 10;
      logic [W-1:0] d = ($urandom % 8 == 0) ? {$urandom, $urandom} : W'($urandom % 16);
      if (op == 9) op = 6;
      issue("rand", op, $urandom % 4, 1'($urandom), $urandom % N, d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule